// File: doc/BRIEF.md
# Interrupt Controller Register Front End

This block is the programming side of an eight-line interrupt controller. Software reaches it over a byte-wide bus with two addresses. Address 0 is the command port and address 1 is the data port. Command writes are decoded into one of three actions:

- start an initialization sequence;
- arm a one-shot read of the in-service register;
- issue an end-of-interrupt that clears in-service bits.

While initialization is open, data-port writes are steered through a short word sequence: vector base, then cascade word, then mode word. Which of these words are expected depends on bits latched from the starting command. Outside initialization, a data write loads the interrupt mask.

The block holds the mask, configuration, vector base, cascade and auto-EOI settings, and the in-service register. It exports all of them to the separate priority logic, together with an end-of-interrupt strobe and its level. The priority logic supplies the request vector and pulses bits into the in-service register when it grants an interrupt.

Both bus ports accept a transfer in every cycle its enable is high. There is no back-pressure: a write takes effect at the next rising edge, and read data is driven in the same cycle as the read enable.

Top module: `icu_prog_seq`

## Requirements
- R1: After reset the mask reads 0xFF. Vector base, cascade word, auto-EOI, in-service register and the busy flag are all 0, and a command-port read returns the request vector.
- R2: A command write with bit 4 (0x10) set raises the busy flag and latches the whole byte as configuration. The next data write is then taken as the vector base.
- R3: A command write with bit 4 clear and bit 3 (0x08) set is a read-select. Only the exact code 0x0B arms the next command-port read to return the in-service register. Other read-select codes, including 0x2B and 0x4B, neither arm the read nor clear in-service bits.
- R4: After a command-port read has returned the in-service register, the select clears and later command-port reads return the request vector.
- R5: A data write while not busy loads the mask. A data-port read always returns the mask.
- R6: The first data write after an initialization start loads the vector base with bits 2:0 forced to zero. If configuration bit 1 is 1 (single) and bit 0 is 0 (no mode word), busy falls.
- R7: With configuration bit 1 at 0 (cascade), the second data write loads the cascade word. Busy falls there if configuration bit 0 is 0.
- R8: The remaining data write is the mode word. Its bit 1 (0x02) loads auto-EOI, and busy falls.
- R9: A command write with bits 4 and 3 clear and bits 5 (0x20) and 6 (0x40) set clears only in-service bit n = data[2:0]. In that cycle it pulses the end-of-interrupt strobe with specific=1 and level n.
- R10: A command write with bits 4 and 3 clear, bit 5 set and bit 6 clear clears the whole in-service register and pulses the strobe with specific=0.
- R11: A command write with bits 5, 4 and 3 all clear changes no register and raises no strobe.
- R12: A bit set on the in-service set input appears in the in-service register at the next edge. It survives an end-of-interrupt issued in the same cycle.
- R13: Data writes while busy leave the mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 1 | 0 = command port, 1 = data port |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 1 | 0 = command port, 1 = data port |
| rd_data | output | 8 | Read byte, valid in the read cycle |
| req_vec | input | 8 | Request vector from priority logic |
| isr_set | input | 8 | In-service set pulses from priority logic |
| mask_o | output | 8 | Interrupt mask |
| cfg_o | output | 8 | Latched configuration byte |
| offset_o | output | 8 | Vector base |
| cascade_o | output | 8 | Cascade word |
| auto_eoi_o | output | 1 | Automatic end-of-interrupt enable |
| init_busy_o | output | 1 | Initialization sequence open |
| isr_o | output | 8 | In-service register |
| eoi_stb_o | output | 1 | End-of-interrupt strobe |
| eoi_specific_o | output | 1 | Strobe targets one level |
| eoi_level_o | output | 3 | Level for a specific end-of-interrupt |

## Verification
Register effects of a write (mask, configuration, vector base, cascade word, auto-EOI, busy flag, in-service bits) are due one rising edge after the write is presented. The bench therefore drives each write at a falling edge and checks the outputs at the following falling edge. Read data and the end-of-interrupt strobe and level are combinational in the cycle the access is presented, so they are sampled one nanosecond after driving, before the rising edge. The one-shot select is checked by a second command read issued after the edge that consumed the first.

// File: rtl/icu_pkg.sv
package icu_pkg;
  // Command byte bit positions
  localparam int unsigned CB_INIT  = 4;
  localparam int unsigned CB_RSEL  = 3;
  localparam int unsigned CB_EOI   = 5;
  localparam int unsigned CB_SPEC  = 6;
  // Configuration byte bit positions
  localparam int unsigned CF_SINGLE = 1;
  localparam int unsigned CF_MODEW  = 0;
  // Mode word bit position
  localparam int unsigned MW_AEOI   = 1;
  // Exact code arming an in-service read
  localparam logic [7:0] RSEL_ISR_CODE = 8'h0B;

  typedef enum logic [1:0] {
    CK_NONE = 2'd0,
    CK_INIT = 2'd1,
    CK_RSEL = 2'd2,
    CK_EOI  = 2'd3
  } cmd_kind_e;
endpackage

// File: rtl/icu_cmd_decode.sv
module icu_cmd_decode
  import icu_pkg::*;
#(
  parameter int unsigned DW = 8,
  localparam int unsigned LVL_W = $clog2(DW)
) (
  input  logic             cmd_wr,
  input  logic [DW-1:0]    cmd_byte,
  output cmd_kind_e        kind,
  output logic             arm_isr,
  output logic             eoi_spec,
  output logic [LVL_W-1:0] eoi_lvl
);
  always_comb begin
    kind = CK_NONE;
    if (cmd_wr) begin
      if (cmd_byte[CB_INIT])      kind = CK_INIT;
      else if (cmd_byte[CB_RSEL]) kind = CK_RSEL;
      else if (cmd_byte[CB_EOI])  kind = CK_EOI;
    end
  end

  assign arm_isr  = (kind == CK_RSEL) && (cmd_byte == DW'(RSEL_ISR_CODE));
  assign eoi_spec = cmd_byte[CB_SPEC];
  assign eoi_lvl  = cmd_byte[LVL_W-1:0];
endmodule

// File: rtl/icu_init_seq.sv
module icu_init_seq
  import icu_pkg::*;
#(
  parameter int unsigned DW      = 8,
  parameter int unsigned OFS_LOW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init_start,
  input  logic [DW-1:0] cmd_byte,
  input  logic          data_wr,
  input  logic [DW-1:0] data_byte,
  output logic [DW-1:0] mask,
  output logic [DW-1:0] cfg,
  output logic [DW-1:0] offset,
  output logic [DW-1:0] cascade,
  output logic          aeoi,
  output logic          busy
);
  localparam logic [DW-1:0] OFS_KEEP = ~DW'((1 << OFS_LOW) - 1);

  logic offset_set;
  logic casc_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask       <= '1;
      cfg        <= '0;
      offset     <= '0;
      cascade    <= '0;
      aeoi       <= 1'b0;
      busy       <= 1'b0;
      offset_set <= 1'b0;
      casc_seen  <= 1'b0;
    end else if (init_start) begin
      busy       <= 1'b1;
      cfg        <= cmd_byte;
      offset_set <= 1'b0;
      casc_seen  <= 1'b0;
    end else if (data_wr) begin
      if (!busy) begin
        mask <= data_byte;
      end else if (!offset_set) begin
        offset     <= data_byte & OFS_KEEP;
        offset_set <= 1'b1;
        if (cfg[CF_SINGLE] && !cfg[CF_MODEW]) busy <= 1'b0;
      end else if (!cfg[CF_SINGLE] && !casc_seen) begin
        cascade   <= data_byte;
        casc_seen <= 1'b1;
        if (!cfg[CF_MODEW]) busy <= 1'b0;
      end else begin
        aeoi <= data_byte[MW_AEOI];
        busy <= 1'b0;
      end
    end
  end

  // R2
  init_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_start |=> (busy && cfg == $past(cmd_byte)));

  // R5
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !init_start && !busy) |=> (mask == $past(data_byte)));

  // R13
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && busy) |=> $stable(mask));

  // R8
  mode_word_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !init_start && busy && offset_set && (cfg[CF_SINGLE] || casc_seen))
      |=> (!busy && aeoi == $past(data_byte[MW_AEOI])));
endmodule

// File: rtl/icu_isr_bank.sv
module icu_isr_bank #(
  parameter int unsigned DW = 8,
  localparam int unsigned LVL_W = $clog2(DW)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DW-1:0]    set_vec,
  input  logic             eoi_fire,
  input  logic             eoi_spec,
  input  logic [LVL_W-1:0] eoi_lvl,
  output logic [DW-1:0]    isr
);
  logic [DW-1:0] clr_vec;

  always_comb begin
    clr_vec = '0;
    if (eoi_fire) begin
      if (eoi_spec) clr_vec[eoi_lvl] = 1'b1;
      else          clr_vec = '1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) isr <= '0;
    else        isr <= (isr & ~clr_vec) | set_vec;
  end

  // R12
  set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((isr & $past(set_vec)) == $past(set_vec)));

  // R10
  eoi_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_fire && !eoi_spec && set_vec == '0) |=> (isr == '0));

  // R11
  no_eoi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!eoi_fire && set_vec == '0) |=> $stable(isr));
endmodule

// File: rtl/icu_read_port.sv
module icu_read_port #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm_isr,
  input  logic          rd_en,
  input  logic          rd_is_data,
  input  logic [DW-1:0] mask,
  input  logic [DW-1:0] req,
  input  logic [DW-1:0] isr,
  output logic [DW-1:0] rd_data
);
  logic sel_isr;
  logic cmd_rd;

  assign cmd_rd = rd_en && !rd_is_data;

  always_ff @(posedge clk) begin
    if (!rst_n)                sel_isr <= 1'b0;
    else if (arm_isr)          sel_isr <= 1'b1;
    else if (cmd_rd && sel_isr) sel_isr <= 1'b0;
  end

  always_comb begin
    if (rd_is_data)   rd_data = mask;
    else if (sel_isr) rd_data = isr;
    else              rd_data = req;
  end

  // R4
  select_one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_rd && sel_isr && !arm_isr) |=> !sel_isr);

  // R3
  select_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm_isr |=> sel_isr);
endmodule

// File: rtl/icu_prog_seq.sv
module icu_prog_seq
  import icu_pkg::*;
#(
  parameter int unsigned DW = 8,
  localparam int unsigned LVL_W = $clog2(DW)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic             rd_en,
  input  logic             rd_addr,
  output logic [DW-1:0]    rd_data,
  input  logic [DW-1:0]    req_vec,
  input  logic [DW-1:0]    isr_set,
  output logic [DW-1:0]    mask_o,
  output logic [DW-1:0]    cfg_o,
  output logic [DW-1:0]    offset_o,
  output logic [DW-1:0]    cascade_o,
  output logic             auto_eoi_o,
  output logic             init_busy_o,
  output logic [DW-1:0]    isr_o,
  output logic             eoi_stb_o,
  output logic             eoi_specific_o,
  output logic [LVL_W-1:0] eoi_level_o
);
  cmd_kind_e        kind;
  logic             arm_isr;
  logic             eoi_spec;
  logic [LVL_W-1:0] eoi_lvl;
  logic             cmd_wr;
  logic             data_wr;

  assign cmd_wr  = wr_en && !wr_addr;
  assign data_wr = wr_en &&  wr_addr;

  icu_cmd_decode #(.DW(DW)) u_dec (
    .cmd_wr   (cmd_wr),
    .cmd_byte (wr_data),
    .kind     (kind),
    .arm_isr  (arm_isr),
    .eoi_spec (eoi_spec),
    .eoi_lvl  (eoi_lvl)
  );

  icu_init_seq #(.DW(DW)) u_init (
    .clk        (clk),
    .rst_n      (rst_n),
    .init_start (kind == CK_INIT),
    .cmd_byte   (wr_data),
    .data_wr    (data_wr),
    .data_byte  (wr_data),
    .mask       (mask_o),
    .cfg        (cfg_o),
    .offset     (offset_o),
    .cascade    (cascade_o),
    .aeoi       (auto_eoi_o),
    .busy       (init_busy_o)
  );

  icu_isr_bank #(.DW(DW)) u_isr (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vec  (isr_set),
    .eoi_fire (kind == CK_EOI),
    .eoi_spec (eoi_spec),
    .eoi_lvl  (eoi_lvl),
    .isr      (isr_o)
  );

  icu_read_port #(.DW(DW)) u_rd (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm_isr    (arm_isr),
    .rd_en      (rd_en),
    .rd_is_data (rd_addr),
    .mask       (mask_o),
    .req        (req_vec),
    .isr        (isr_o),
    .rd_data    (rd_data)
  );

  assign eoi_stb_o      = (kind == CK_EOI);
  assign eoi_specific_o = eoi_stb_o && eoi_spec;
  assign eoi_level_o    = eoi_lvl;

  // R9
  eoi_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_stb_o && eoi_specific_o && isr_set == '0) |=> (isr_o[$past(eoi_level_o)] == 1'b0));
endmodule

// File: tb/tb_icu_prog_seq.sv
`timescale 1ns/1ps
module tb_icu_prog_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, wr_addr = 1'b0, rd_en = 1'b0, rd_addr = 1'b0;
  logic [7:0] wr_data = '0, req_vec = '0, isr_set = '0;
  logic [7:0] rd_data, mask_o, cfg_o, offset_o, cascade_o, isr_o;
  logic       auto_eoi_o, init_busy_o, eoi_stb_o, eoi_specific_o;
  logic [2:0] eoi_level_o;
  logic       stb_s, spec_s;
  logic [2:0] lvl_s;
  int n_chk = 0, n_err = 0;

  always #4 clk = ~clk;

  icu_prog_seq dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .req_vec(req_vec),
    .isr_set(isr_set), .mask_o(mask_o), .cfg_o(cfg_o), .offset_o(offset_o),
    .cascade_o(cascade_o), .auto_eoi_o(auto_eoi_o), .init_busy_o(init_busy_o),
    .isr_o(isr_o), .eoi_stb_o(eoi_stb_o), .eoi_specific_o(eoi_specific_o),
    .eoi_level_o(eoi_level_o)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    #1;
    stb_s = eoi_stb_o; spec_s = eoi_specific_o; lvl_s = eoi_level_o;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic set_isr(input logic [7:0] v);
    @(negedge clk); isr_set = v;
    @(negedge clk); isr_set = '0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    logic [7:0] codes [10];
    codes = '{8'h08, 8'h09, 8'h0A, 8'h0B, 8'h0C, 8'h0D, 8'h0E, 8'h0F, 8'h2B, 8'h4B};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    req_vec = 8'h3C;
    @(negedge clk);
    // R1 reset state
    chk("R1 mask", mask_o, 8'hFF);
    chk("R1 offset", offset_o, 0);
    chk("R1 cascade", cascade_o, 0);
    chk("R1 aeoi", auto_eoi_o, 0);
    chk("R1 busy", init_busy_o, 0);
    chk("R1 isr", isr_o, 0);
    rd(1'b0, d); chk("R1 cmd read", d, 8'h3C);

    // R5 mask sweep
    for (int v = 0; v < 256; v++) begin
      wr(1'b1, 8'(v));
      chk("R5 mask_o", mask_o, v);
      rd(1'b1, d); chk("R5 data read", d, v);
    end

    // R2 R6 R7 R8 R13 over all single/mode-word combinations
    for (int c = 0; c < 4; c++) begin
      logic single, modew, busy_exp;
      logic [7:0] cfg;
      single = c[1]; modew = c[0];
      cfg = 8'h10 | 8'(c) | 8'h80;
      wr(1'b1, 8'h5A);
      wr(1'b0, cfg);
      chk("R2 busy", init_busy_o, 1);
      chk("R2 cfg", cfg_o, cfg);
      wr(1'b1, 8'hA8 + 8'(c) + 8'h05);
      chk("R6 offset", offset_o, (8'hAD + 8'(c)) & 8'hF8);
      busy_exp = !(single && !modew);
      chk("R6 busy", init_busy_o, busy_exp);
      if (!single) begin
        wr(1'b1, 8'h04 + 8'(c));
        chk("R7 cascade", cascade_o, 8'h04 + c);
        busy_exp = modew;
        chk("R7 busy", init_busy_o, busy_exp);
      end
      if (busy_exp) begin
        wr(1'b1, (c % 2 == 1) ? 8'h02 : 8'hFD);
        chk("R8 aeoi", auto_eoi_o, (c % 2 == 1) ? 1 : 0);
        chk("R8 busy", init_busy_o, 0);
      end
      chk("R13 mask kept", mask_o, 8'h5A);
    end

    // R9 specific EOI at every level
    for (int n = 0; n < 8; n++) begin
      set_isr(8'hFF);
      wr(1'b0, 8'h60 | 8'(n));
      chk("R9 strobe", {stb_s, spec_s, lvl_s}, {1'b1, 1'b1, 3'(n)});
      chk("R9 isr", isr_o, 8'hFF & ~(8'h01 << n));
    end

    // R10 whole clear
    set_isr(8'hC3);
    wr(1'b0, 8'h20);
    chk("R10 strobe", {stb_s, spec_s}, 2'b10);
    chk("R10 isr", isr_o, 0);
    set_isr(8'h5A);
    wr(1'b0, 8'hA7);
    chk("R10 isr b7", isr_o, 0);

    // R11 ignored commands
    set_isr(8'h81);
    wr(1'b0, 8'h00); chk("R11 strobe 00", stb_s, 0);
    wr(1'b0, 8'h47); chk("R11 strobe 47", stb_s, 0);
    wr(1'b0, 8'h80); chk("R11 strobe 80", stb_s, 0);
    chk("R11 isr", isr_o, 8'h81);
    chk("R11 busy", init_busy_o, 0);
    rd(1'b0, d); chk("R11 cmd read", d, 8'h3C);

    // R3 R4 read-select codes
    foreach (codes[i]) begin
      wr(1'b0, codes[i]);
      chk("R3 isr untouched", isr_o, 8'h81);
      rd(1'b0, d);
      chk("R3 first read", d, (codes[i] == 8'h0B) ? 8'h81 : 8'h3C);
      rd(1'b0, d);
      chk("R4 second read", d, 8'h3C);
    end
    wr(1'b0, 8'h0B);
    rd(1'b1, d); chk("R5 data read while armed", d, 8'h5A);
    rd(1'b0, d); chk("R4 armed survives data read", d, 8'h81);

    // R12 set wins over same-cycle clear
    wr(1'b0, 8'h20);
    @(negedge clk);
    isr_set = 8'h04; wr_en = 1'b1; wr_addr = 1'b0; wr_data = 8'h62;
    @(negedge clk);
    isr_set = '0; wr_en = 1'b0;
    chk("R12 specific", isr_o, 8'h04);
    set_isr(8'hF0);
    @(negedge clk);
    isr_set = 8'h08; wr_en = 1'b1; wr_addr = 1'b0; wr_data = 8'h20;
    @(negedge clk);
    isr_set = '0; wr_en = 1'b0;
    chk("R12 all", isr_o, 8'h08);

    finish_run();
  end
endmodule